// File: doc/BRIEF.md
# Locked ATA Timing Register Window

This block sits on a byte-wide, eight-offset I/O window that it shares with an ATA task-file decoder. While locked it is transparent. Every access is forwarded to the task-file side through a select strobe, and the task-file read data is returned on the bus. The block also watches the stream of accesses for an ordered unlock pattern. The pattern is two back-to-back 16-bit reads at offset 1, then a byte write of 0x03 to offset 2. Once that pattern completes, the task file disappears from the window and a bank of timing configuration registers takes its place.

Inside the bank, software picks a device with a select field in the miscellaneous register. It then stages a read-cycle timing byte and a write-cycle timing byte for that device. In each byte, the upper nibble is the active-pulse count and the lower nibble is the recovery count. The miscellaneous register also carries a shared address-setup field. Writing the commit code to the control register copies all staged values to the active outputs: set 0 drives device 0 and set 1 drives device 1. A relock key written to offset 2 restores task-file decoding. A clock strap input is registered, exported, and readable in the bank.

Top module: `ata_timing_regwin`

## Requirements
- R1: After reset the window is locked, every active read and write timing byte is 0xFF, every staged timing byte is 0xFF, the active setup code is 3, and the miscellaneous register reads 0x30 (setup 3, device 0).
- R2: While locked, every access asserts `tf_sel_o` in the same cycle, and `bus_rdata_o` equals `tf_rdata_i` for every offset.
- R3: The window unlocks after two or more consecutive wide reads at offset 1 that are immediately followed by a write of 0x03 to offset 2. From the next access on, `tf_sel_o` stays low and reads return bank data.
- R4: If any other access intervenes, the window stays locked and the tracker returns to idle. This covers a byte read at offset 1, an access at another offset, a write at offset 1, a single wide read, and a key value other than 0x03.
- R5: While unlocked, offset 0 holds the read-timing byte and offset 1 holds the write-timing byte of the selected set. Offset 6 is the miscellaneous register and offset 5 is the strap register. Offsets 2, 3, 4 and 7 read as 0x00.
- R6: Bit 0 of the miscellaneous register selects the timing set that offsets 0 and 1 write and read (0 = device 0, 1 = device 1). The set that is not selected is left unchanged.
- R7: Bits 5:4 of the miscellaneous register hold the staged address-setup code. The register reads back as setup code in bits 5:4 and device select in bit 0, with all other bits 0.
- R8: A write of 0x85 to offset 3 copies both staged sets and the staged setup code to the active outputs, one clock edge after the write. Any other value written to offset 3 leaves the active outputs unchanged.
- R9: `clk_strap_o` follows `strap_pin_i` one clock edge later (0 = 33 MHz bus clock, 1 = 25 MHz). Offset 5 reads that bit in bit 0 with all other bits 0.
- R10: While unlocked, writing 0x83 to offset 2 relocks the window and leaves the tracker idle. Other values written to offset 2 have no effect. The active outputs keep their values across a relock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_addr_i | input | 3 | Window offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (task file or bank) |
| tf_sel_o | output | 1 | Access strobe forwarded to the task-file decoder |
| tf_rdata_i | input | 8 | Read data from the task-file decoder |
| strap_pin_i | input | 1 | Bus clock strap |
| act_rd_tim_o | output | NUM_DEV x 8 | Active read-cycle timing per device |
| act_wr_tim_o | output | NUM_DEV x 8 | Active write-cycle timing per device |
| act_setup_o | output | 2 | Active shared address-setup code |
| clk_strap_o | output | 1 | Registered clock strap |

## Verification
Read data and `tf_sel_o` are combinational on the current access, so the bench samples them 1 ns after it drives an access, which is still before the clock edge. Unlock and relock take effect at the edge that ends the key write, and a commit updates the active outputs at the edge that ends the 0x85 write. For those results the bench probes on the following access or at the next falling edge. The strap register has a single stage, so the bench waits two full cycles after moving the strap pin before it reads offset 5 or checks `clk_strap_o`. A sweep over all 256 timing values alternates the device select and the setup code, and it compares both devices' outputs against a staged and active model held in the bench.

// File: rtl/ata_regwin_pkg.sv
package ata_regwin_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_e;

    // Window offsets whose meaning the access sequence or bank decode depends on
    localparam logic [ADDR_W-1:0] OFS_RDTIM = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_WRTIM = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_PROBE = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_KEY   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_STRAP = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_MISC  = 3'd6;

    localparam logic [7:0] KEY_OPEN   = 8'h03;
    localparam logic [7:0] KEY_CLOSE  = 8'h83;
    localparam logic [7:0] CMD_COMMIT = 8'h85;

endpackage

// File: rtl/regwin_unlock_fsm.sv
module regwin_unlock_fsm
    import ata_regwin_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              acc_i,
    input  logic              wr_i,
    input  logic              wide_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              unlocked_o
);

    typedef struct packed {
        seq_e seq;
        logic unlocked;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    logic probe_rd, open_wr, close_wr;

    always_comb begin
        probe_rd = !wr_i && wide_i && (addr_i == OFS_PROBE);
        open_wr  = wr_i && (addr_i == OFS_KEY) && (wdata_i == DATA_W'(KEY_OPEN));
        close_wr = wr_i && (addr_i == OFS_KEY) && (wdata_i == DATA_W'(KEY_CLOSE));
        nxt_d    = cur_q;
        if (acc_i) begin
            if (!cur_q.unlocked) begin
                if (probe_rd) begin
                    nxt_d.seq = (cur_q.seq == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
                end else if (open_wr && (cur_q.seq == SEQ_TWO)) begin
                    nxt_d.unlocked = 1'b1;
                    nxt_d.seq      = SEQ_IDLE;
                end else begin
                    nxt_d.seq = SEQ_IDLE;
                end
            end else if (close_wr) begin
                nxt_d.unlocked = 1'b0;
                nxt_d.seq      = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q <= '{seq: SEQ_IDLE, unlocked: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign unlocked_o = cur_q.unlocked;

    // R3
    unlock_needs_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cur_q.unlocked) |-> $past(acc_i && wr_i && addr_i == OFS_KEY
                                        && wdata_i == DATA_W'(KEY_OPEN)));

    // R4
    unlock_needs_two_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cur_q.unlocked) |-> $past(cur_q.seq == SEQ_TWO));

    // R10
    relock_needs_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(cur_q.unlocked) |-> $past(acc_i && wr_i && addr_i == OFS_KEY
                                        && wdata_i == DATA_W'(KEY_CLOSE)));

endmodule

// File: rtl/regwin_timing_bank.sv
module regwin_timing_bank
    import ata_regwin_pkg::*;
#(
    parameter int              DATA_W       = 8,
    parameter int              NUM_DEV      = 2,
    parameter int              SETUP_W      = 2,
    parameter int              SETUP_LSB    = 4,
    parameter logic [7:0]      RESET_TIMING = 8'hFF,
    parameter logic [SETUP_W-1:0] RESET_SETUP = '1
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wdata_i,
    input  logic                            strap_pin_i,
    output logic [DATA_W-1:0]               rdata_o,
    output logic [NUM_DEV-1:0][DATA_W-1:0]  act_rd_o,
    output logic [NUM_DEV-1:0][DATA_W-1:0]  act_wr_o,
    output logic [SETUP_W-1:0]              act_setup_o,
    output logic                            strap_o
);

    localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    typedef struct packed {
        logic [NUM_DEV-1:0][DATA_W-1:0] stg_rd;
        logic [NUM_DEV-1:0][DATA_W-1:0] stg_wr;
        logic [NUM_DEV-1:0][DATA_W-1:0] act_rd;
        logic [NUM_DEV-1:0][DATA_W-1:0] act_wr;
        logic [SETUP_W-1:0]             stg_setup;
        logic [SETUP_W-1:0]             act_setup;
        logic [DEV_W-1:0]               dev_sel;
        logic                           strap;
    } bank_t;

    bank_t cur_q, nxt_d;
    logic  commit_hit;
    logic [DATA_W-1:0] misc_view;

    always_comb begin
        nxt_d      = cur_q;
        commit_hit = wr_en_i && (addr_i == OFS_CTRL) && (wdata_i == DATA_W'(CMD_COMMIT));
        nxt_d.strap = strap_pin_i;
        if (wr_en_i) begin
            case (addr_i)
                OFS_RDTIM: nxt_d.stg_rd[cur_q.dev_sel] = wdata_i;
                OFS_WRTIM: nxt_d.stg_wr[cur_q.dev_sel] = wdata_i;
                OFS_MISC: begin
                    nxt_d.stg_setup = wdata_i[SETUP_LSB +: SETUP_W];
                    nxt_d.dev_sel   = wdata_i[DEV_W-1:0];
                end
                default: ;
            endcase
        end
        if (commit_hit) begin
            nxt_d.act_rd    = cur_q.stg_rd;
            nxt_d.act_wr    = cur_q.stg_wr;
            nxt_d.act_setup = cur_q.stg_setup;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.stg_rd    <= {NUM_DEV{DATA_W'(RESET_TIMING)}};
            cur_q.stg_wr    <= {NUM_DEV{DATA_W'(RESET_TIMING)}};
            cur_q.act_rd    <= {NUM_DEV{DATA_W'(RESET_TIMING)}};
            cur_q.act_wr    <= {NUM_DEV{DATA_W'(RESET_TIMING)}};
            cur_q.stg_setup <= RESET_SETUP;
            cur_q.act_setup <= RESET_SETUP;
            cur_q.dev_sel   <= '0;
            cur_q.strap     <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        misc_view                          = '0;
        misc_view[SETUP_LSB +: SETUP_W]    = cur_q.stg_setup;
        misc_view[DEV_W-1:0]               = cur_q.dev_sel;
        case (addr_i)
            OFS_RDTIM: rdata_o = cur_q.stg_rd[cur_q.dev_sel];
            OFS_WRTIM: rdata_o = cur_q.stg_wr[cur_q.dev_sel];
            OFS_MISC:  rdata_o = misc_view;
            OFS_STRAP: rdata_o = DATA_W'(cur_q.strap);
            default:   rdata_o = '0;
        endcase
    end

    assign act_rd_o    = cur_q.act_rd;
    assign act_wr_o    = cur_q.act_wr;
    assign act_setup_o = cur_q.act_setup;
    assign strap_o     = cur_q.strap;

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev_chk
        // R8
        act_moves_on_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$stable(cur_q.act_rd[g]) |-> $past(wr_en_i && addr_i == OFS_CTRL
                                                && wdata_i == DATA_W'(CMD_COMMIT)));
        // R8
        commit_copies_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_en_i && addr_i == OFS_CTRL && wdata_i == DATA_W'(CMD_COMMIT))
            |=> (cur_q.act_wr[g] == $past(cur_q.stg_wr[g])));
    end

    // R9
    strap_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (strap_o == $past(strap_pin_i)));

endmodule

// File: rtl/ata_timing_regwin.sv
module ata_timing_regwin
    import ata_regwin_pkg::*;
#(
    parameter int         DATA_W       = 8,
    parameter int         NUM_DEV      = 2,
    parameter logic [7:0] RESET_TIMING = 8'hFF
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           bus_sel_i,
    input  logic                           bus_wr_i,
    input  logic                           bus_wide_i,
    input  logic [2:0]                     bus_addr_i,
    input  logic [DATA_W-1:0]              bus_wdata_i,
    output logic [DATA_W-1:0]              bus_rdata_o,
    output logic                           tf_sel_o,
    input  logic [DATA_W-1:0]              tf_rdata_i,
    input  logic                           strap_pin_i,
    output logic [NUM_DEV-1:0][DATA_W-1:0] act_rd_tim_o,
    output logic [NUM_DEV-1:0][DATA_W-1:0] act_wr_tim_o,
    output logic [1:0]                     act_setup_o,
    output logic                           clk_strap_o
);

    logic              unlocked;
    logic [DATA_W-1:0] bank_rdata;

    regwin_unlock_fsm #(
        .DATA_W (DATA_W)
    ) unlock_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .acc_i      (bus_sel_i),
        .wr_i       (bus_wr_i),
        .wide_i     (bus_wide_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .unlocked_o (unlocked)
    );

    regwin_timing_bank #(
        .DATA_W       (DATA_W),
        .NUM_DEV      (NUM_DEV),
        .SETUP_W      (2),
        .SETUP_LSB    (4),
        .RESET_TIMING (RESET_TIMING),
        .RESET_SETUP  (2'd3)
    ) bank_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (bus_sel_i && bus_wr_i && unlocked),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .strap_pin_i (strap_pin_i),
        .rdata_o     (bank_rdata),
        .act_rd_o    (act_rd_tim_o),
        .act_wr_o    (act_wr_tim_o),
        .act_setup_o (act_setup_o),
        .strap_o     (clk_strap_o)
    );

    always_comb begin
        tf_sel_o    = bus_sel_i && !unlocked;
        bus_rdata_o = unlocked ? bank_rdata : tf_rdata_i;
    end

    // R2
    tf_hidden_when_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(bus_sel_i && bus_wr_i && bus_addr_i == OFS_KEY
              && bus_wdata_i == DATA_W'(KEY_OPEN) && tf_sel_o && !unlocked)
        && unlocked |-> !tf_sel_o);

endmodule

// File: tb/ata_timing_regwin_tb_top.sv
module ata_timing_regwin_tb_top;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel = 1'b0, wr = 1'b0, wide = 1'b0;
    logic [2:0]      addr = '0;
    logic [7:0]      wdata = '0, tf_rdata = '0;
    logic            strap = 1'b0;
    logic [7:0]      rdata;
    logic            tf_sel;
    logic [1:0][7:0] act_rd, act_wr;
    logic [1:0]      act_setup;
    logic            strap_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] rd_s;
    logic       tf_s;
    logic [1:0][7:0] m_stg_rd, m_stg_wr, m_act_rd, m_act_wr;
    logic [1:0] m_stg_setup, m_act_setup;

    always #(CLK_PERIOD/2) clk = ~clk;

    ata_timing_regwin dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_wide_i(wide),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .tf_sel_o(tf_sel),
        .tf_rdata_i(tf_rdata), .strap_pin_i(strap), .act_rd_tim_o(act_rd),
        .act_wr_tim_o(act_wr), .act_setup_o(act_setup), .clk_strap_o(strap_out)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic acc(bit w, bit wd, logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = w; wide = wd; addr = a; wdata = d;
        #1;
        rd_s = rdata;
        tf_s = tf_sel;
        @(posedge clk);
        #1;
        sel = 1'b0; wr = 1'b0; wide = 1'b0;
    endtask

    task automatic expect_locked(string req);
        tf_rdata = 8'hA5;
        acc(0, 0, 3'd0, 8'h00);
        chk(req, {7'b0, tf_s}, 8'h01);
        chk(req, rd_s, 8'hA5);
    endtask

    task automatic expect_open(string req);
        acc(0, 0, 3'd6, 8'h00);
        chk(req, {7'b0, tf_s}, 8'h00);
        chk(req, rd_s, {2'b00, m_stg_setup, 4'b0000});
    endtask

    task automatic check_outputs(string req);
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk(req, act_rd[d], m_act_rd[d]);
            chk(req, act_wr[d], m_act_wr[d]);
        end
        chk(req, {6'b0, act_setup}, {6'b0, m_act_setup});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_stg_rd = {2{8'hFF}}; m_stg_wr = {2{8'hFF}};
        m_act_rd = {2{8'hFF}}; m_act_wr = {2{8'hFF}};
        m_stg_setup = 2'd3; m_act_setup = 2'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check_outputs("R1");
        chk("R1 idle tf_sel", {7'b0, tf_sel}, 8'h00);

        // R2 pass-through at every offset
        for (int a = 0; a < 8; a++) begin
            tf_rdata = 8'(a * 8'h11 + 8'h03);
            acc(0, 0, 3'(a), 8'h00);
            chk("R2 rdata", rd_s, 8'(a * 8'h11 + 8'h03));
            chk("R2 tf_sel", {7'b0, tf_s}, 8'h01);
        end

        // R4 broken sequences
        acc(0, 1, 3'd1, 0); acc(0, 0, 3'd1, 0); acc(1, 0, 3'd2, 8'h03);
        expect_locked("R4 byte read");
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd0, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 8'h03);
        expect_locked("R4 other offset");
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd1, 8'h03); acc(1, 0, 3'd2, 8'h03);
        expect_locked("R4 write at 1");
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 8'h04);
        expect_locked("R4 wrong key");
        acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 8'h03);
        expect_locked("R4 single read");

        // R3 unlock (three reads also accepted)
        acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(0, 1, 3'd1, 0); acc(1, 0, 3'd2, 8'h03);
        expect_open("R3 unlocked");
        acc(0, 0, 3'd0, 0);
        chk("R1 staged default", rd_s, 8'hFF);

        // R5 unused offsets
        acc(0, 0, 3'd2, 0); chk("R5 ofs2", rd_s, 8'h00);
        acc(0, 0, 3'd3, 0); chk("R5 ofs3", rd_s, 8'h00);
        acc(0, 0, 3'd4, 0); chk("R5 ofs4", rd_s, 8'h00);
        acc(0, 0, 3'd7, 0); chk("R5 ofs7", rd_s, 8'h00);

        // R9 strap
        for (int s = 0; s < 4; s++) begin
            strap = s[0] ^ 1'b1;
            repeat (2) @(negedge clk);
            chk("R9 strap out", {7'b0, strap_out}, {7'b0, strap});
            acc(0, 0, 3'd5, 0);
            chk("R9 strap reg", rd_s, {7'b0, strap});
        end

        // R6 R7 R8 sweep over every timing value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            logic       dv;
            vb = 8'(v);
            dv = vb[0];
            acc(1, 0, 3'd6, {2'b00, vb[5:4], 3'b000, dv});
            m_stg_setup = vb[5:4];
            acc(0, 0, 3'd6, 0);
            chk("R7 misc readback", rd_s, {2'b00, vb[5:4], 3'b000, dv});
            acc(1, 0, 3'd0, vb);
            acc(1, 0, 3'd1, vb ^ 8'h5A);
            m_stg_rd[dv] = vb;
            m_stg_wr[dv] = vb ^ 8'h5A;
            acc(0, 0, 3'd0, 0);
            chk("R6 rd timing of selected set", rd_s, m_stg_rd[dv]);
            acc(0, 0, 3'd1, 0);
            chk("R6 wr timing of selected set", rd_s, m_stg_wr[dv]);
            acc(1, 0, 3'd3, 8'h85);
            m_act_rd = m_stg_rd; m_act_wr = m_stg_wr; m_act_setup = m_stg_setup;
            check_outputs("R8 commit");
        end

        // R8 non-commit codes are ignored
        acc(1, 0, 3'd6, 8'h00);
        m_stg_setup = 2'd0;
        acc(1, 0, 3'd0, 8'h12);
        m_stg_rd[0] = 8'h12;
        acc(1, 0, 3'd3, 8'h84);
        check_outputs("R8 code 84 ignored");
        acc(1, 0, 3'd3, 8'h05);
        check_outputs("R8 code 05 ignored");
        acc(0, 0, 3'd0, 0);
        chk("R6 set0 staged", rd_s, 8'h12);

        // R10 stray key values, relock, tracker idle afterwards
        acc(1, 0, 3'd2, 8'h55);
        expect_open("R10 stray key");
        acc(1, 0, 3'd2, 8'h03);
        expect_open("R10 open key while open");
        acc(1, 0, 3'd2, 8'h83);
        expect_locked("R10 relocked");
        check_outputs("R10 outputs kept");
        acc(1, 0, 3'd2, 8'h03);
        expect_locked("R10 tracker idle");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule